// File: doc/BRIEF.md
# Four-Channel DAC Serial Front End

This block is the digital side of a four-channel converter that takes its codes over a three-wire serial link. A host lowers a select line, clocks a frame in most significant bit first on rising serial-clock edges, and raises select again. The rising select edge acts on the frame held in the shift register. It either writes a code into one channel's staging register or puts channels into power-down. Data lands in the staging register only; a shared active-low load level copies all four staging registers into the output registers together, so every channel can change in the same cycle.

The serial clock, select, data and load inputs are asynchronous to the system clock and pass through two-flop synchronizers. Edges are found in the system-clock domain. The system reset `rst_n` clears everything. The separate clear input `clr_n` zeroes the staging and output registers but does not touch the shift register or the power-down flags. Both resets assert at once and release in step with the clock.

Top module: `qdac_frontend`

## Requirements
- R1: A frame is FRAME_W = DATA_W+4 bits (16 by default), shifted MSB first. Bit FRAME_W-1 is the power-down-all flag, bit FRAME_W-2 is the power-down-one flag, the next two bits are the channel address, and the low DATA_W bits are the code.
- R2: The shift register advances only on a rising serial-clock edge seen while select is low. Serial-clock and data activity while select is high leaves it unchanged.
- R3: On a rising edge of select with both flags zero, the code is written to the staging register of the addressed channel (0=A, 1=B, 2=C, 3=D), and no other staging register changes.
- R4: On a rising edge of select with the power-down-all flag set, all four channels enter power-down, whatever the address.
- R5: On a rising edge of select with only the power-down-one flag set, only the addressed channel enters power-down, and no staging register changes.
- R6: While the synchronized load input is low, every output register follows its staging register. While it is high, the output registers hold their values.
- R7: `clr_n` low zeroes all staging and output registers at once and keeps the shift-register contents, so a frame shifted in before the clear still commits correctly afterwards.
- R8: After `rst_n`, all outputs are zero and no channel is in power-down.
- R9: The output of a channel in power-down reads zero. A normal write to a channel takes it out of power-down, and its output then shows its output register. A normal write after power-down-all releases only the addressed channel.
- R10: When more than FRAME_W bits are clocked during one select-low period, only the last FRAME_W bits are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low, asynchronous assert |
| clr_n | input | 1 | Code clear, active low, asynchronous assert |
| ser_clk | input | 1 | Serial clock, data taken on the rising edge |
| ser_sel_n | input | 1 | Serial select, active low; its rising edge commits the frame |
| ser_din | input | 1 | Serial data |
| load_n | input | 1 | Load level, active low, shared by all channels |
| dac_out | output | 4*DATA_W | Channel codes; channel i is at bits [i*DATA_W +: DATA_W], forced to zero in power-down |
| chan_off | output | 4 | Power-down flag per channel, bit i for channel i |

## Verification
The bench first checks that a committed write shows nothing until the load level, because a design without double buffering would update the output early. It replays a stored frame by toggling select alone after clocking junk with select high, so a shifter that ignores select is caught by the wrong code. It sends a 24-bit burst to catch a shifter that freezes after 16 bits. It clears while a frame is still pending, which catches a clear that also wipes the shift register. Finally it walks power-down, single and all, then wakes the channels one at a time. A design that releases every channel on one write, or that reloads the output register on wake-up, shows wrong flags or codes.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int ADDR_W = 2;
  localparam int NCH    = 1 << ADDR_W;
  localparam int HDR_W  = ADDR_W + 2;

  typedef enum logic [1:0] {
    CMD_WRITE   = 2'd0,
    CMD_OFF_ONE = 2'd1,
    CMD_OFF_ALL = 2'd2
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic all_f, input logic one_f);
    if (all_f)      return CMD_OFF_ALL;
    else if (one_f) return CMD_OFF_ONE;
    else            return CMD_WRITE;
  endfunction
endpackage

// File: rtl/qdac_reset_sync.sv
module qdac_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_q_n <= stage_q;
    end
  end
endmodule

// File: rtl/qdac_sync2.sv
module qdac_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               sel_s,
  input  logic               din_s,
  output logic [FRAME_W-1:0] frame,
  output logic               commit
);
  logic               sclk_d, sel_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic               shift_en;

  assign shift_en = sclk_s & ~sclk_d & ~sel_s;
  assign commit   = sel_s & ~sel_d;
  assign frame    = shreg_q;

  always_comb begin
    shreg_d = shreg_q;
    if (shift_en) shreg_d = {shreg_q[FRAME_W-2:0], din_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      sel_d   <= 1'b1;
      shreg_q <= '0;
    end else begin
      sclk_d  <= sclk_s;
      sel_d   <= sel_s;
      shreg_q <= shreg_d;
    end
  end

  // R2: nothing shifts while select is high
  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> $stable(shreg_q));
endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank
  import qdac_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int FRAME_W = DATA_W + HDR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  data_rst_n,
  input  logic                  commit,
  input  logic [FRAME_W-1:0]    frame,
  input  logic                  load_s,
  output logic [NCH*DATA_W-1:0] dac_out,
  output logic [NCH-1:0]        chan_off
);
  logic [NCH-1:0][DATA_W-1:0] in_q, in_d, dac_q, dac_d;
  logic [NCH-1:0]             off_q, off_d;
  logic [ADDR_W-1:0]          addr;
  logic [DATA_W-1:0]          code;
  cmd_e                       cmd;

  assign cmd  = decode_cmd(frame[FRAME_W-1], frame[FRAME_W-2]);
  assign addr = frame[DATA_W +: ADDR_W];
  assign code = frame[DATA_W-1:0];

  always_comb begin
    in_d  = in_q;
    off_d = off_q;
    if (commit) begin
      unique case (cmd)
        CMD_OFF_ALL: off_d = '1;
        CMD_OFF_ONE: off_d[addr] = 1'b1;
        default: begin
          in_d[addr]  = code;
          off_d[addr] = 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    dac_d = dac_q;
    if (!load_s) dac_d = in_q;
  end

  always_ff @(posedge clk or negedge data_rst_n) begin
    if (!data_rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      in_q  <= in_d;
      dac_q <= dac_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= '0;
    else        off_q <= off_d;
  end

  assign chan_off = off_q;

  for (genvar i = 0; i < NCH; i++) begin : g_out
    assign dac_out[i*DATA_W +: DATA_W] = off_q[i] ? '0 : dac_q[i];
  end

  // R4: power-down-all reaches every channel
  assert_all_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cmd == CMD_OFF_ALL) |=> (&off_q));
  // R6: output registers hold while load is high
  assert_dac_hold_R6: assert property (@(posedge clk) disable iff (!data_rst_n)
    load_s |=> $stable(dac_q));
  // R6: output registers follow staging while load is low
  assert_dac_follow_R6: assert property (@(posedge clk) disable iff (!data_rst_n)
    !load_s |=> (dac_q == $past(in_q)));
  // R9: a normal write wakes the addressed channel
  assert_write_wakes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cmd == CMD_WRITE) |=> !off_q[$past(addr)]);
  // R7: clear holds all codes at zero
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rst_n |-> (in_q == '0 && dac_q == '0));
endmodule

// File: rtl/qdac_frontend.sv
module qdac_frontend
  import qdac_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_n,
  input  logic                  ser_clk,
  input  logic                  ser_sel_n,
  input  logic                  ser_din,
  input  logic                  load_n,
  output logic [NCH*DATA_W-1:0] dac_out,
  output logic [NCH-1:0]        chan_off
);
  localparam int FRAME_W = DATA_W + HDR_W;
  localparam int NSYNC   = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b1010; // load_n, din, sel, sclk

  logic               rst_q_n, clr_q_n, data_rst_n;
  logic [NSYNC-1:0]   raw_in, sync_out;
  logic [FRAME_W-1:0] frame;
  logic               commit;

  qdac_reset_sync u_rst_sync (.clk(clk), .arst_n(rst_n), .rst_q_n(rst_q_n));
  qdac_reset_sync u_clr_sync (.clk(clk), .arst_n(rst_n & clr_n), .rst_q_n(clr_q_n));

  assign data_rst_n = rst_q_n & clr_q_n;
  assign raw_in     = {load_n, ser_din, ser_sel_n, ser_clk};

  for (genvar i = 0; i < NSYNC; i++) begin : g_sync
    qdac_sync2 #(.RST_VAL(SYNC_RST[i])) u_sync (
      .clk(clk), .rst_n(rst_q_n), .d(raw_in[i]), .q(sync_out[i]));
  end

  qdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_q_n),
    .sclk_s(sync_out[0]), .sel_s(sync_out[1]), .din_s(sync_out[2]),
    .frame(frame), .commit(commit));

  qdac_chan_bank #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_bank (
    .clk(clk), .rst_n(rst_q_n), .data_rst_n(data_rst_n),
    .commit(commit), .frame(frame), .load_s(sync_out[3]),
    .dac_out(dac_out), .chan_off(chan_off));
endmodule

// File: tb/qdac_frontend_tb.sv
module qdac_frontend_tb;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst_n, clr_n, ser_clk, ser_sel_n, ser_din, load_n;
  logic [4*DW-1:0] dac_out;
  logic [3:0]      chan_off;
  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  qdac_frontend #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ser_clk(ser_clk),
    .ser_sel_n(ser_sel_n), .ser_din(ser_din), .load_n(load_n),
    .dac_out(dac_out), .chan_off(chan_off));

  function automatic logic [15:0] mk(input logic all_f, input logic one_f,
                                     input logic [1:0] a, input logic [11:0] c);
    return {all_f, one_f, a, c};
  endfunction

  function automatic logic [11:0] ch(input int i);
    return dac_out[i*DW +: DW];
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = v[i];
      wait_clk(3);
      ser_clk = 1'b1;
      wait_clk(3);
      ser_clk = 1'b0;
    end
    wait_clk(3);
  endtask

  task automatic send(input logic [15:0] f);
    ser_sel_n = 1'b0;
    wait_clk(3);
    shift_bits({16'h0, f}, 16);
    ser_sel_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    wait_clk(5);
    load_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic t_reset();
    chk("R8 outputs after reset", dac_out, '0);
    chk("R8 power-down after reset", chan_off, 4'b0000);
  endtask

  task automatic t_write_all();
    send(mk(0, 0, 2'd0, 12'hABC));
    send(mk(0, 0, 2'd1, 12'h123));
    send(mk(0, 0, 2'd2, 12'hFFF));
    send(mk(0, 0, 2'd3, 12'h001));
    chk("R6 outputs held before load", dac_out, '0);
    pulse_load();
    chk("R3 R1 channel A", ch(0), 12'hABC);
    chk("R3 channel B", ch(1), 12'h123);
    chk("R3 channel C", ch(2), 12'hFFF);
    chk("R3 channel D", ch(3), 12'h001);
  endtask

  task automatic t_sel_high();
    send(mk(0, 0, 2'd0, 12'h111));
    // junk clocking with select high
    shift_bits(32'h0000_5A5A, 16);
    ser_sel_n = 1'b0;
    wait_clk(4);
    ser_sel_n = 1'b1;
    wait_clk(8);
    pulse_load();
    chk("R2 stored frame survives select-high clocks", ch(0), 12'h111);
    chk("R3 channel B untouched", ch(1), 12'h123);
  endtask

  task automatic t_off_one();
    send(mk(0, 1, 2'd2, 12'h000));
    chk("R5 only C powered down", chan_off, 4'b0100);
    chk("R9 C output zero in power-down", ch(2), 12'h000);
    pulse_load();
    chk("R5 D staging unchanged", ch(3), 12'h001);
    send(mk(0, 0, 2'd2, 12'h5A5));
    chk("R9 C woken by write", chan_off, 4'b0000);
    chk("R9 C shows held output register", ch(2), 12'hFFF);
    pulse_load();
    chk("R9 C new code after load", ch(2), 12'h5A5);
  endtask

  task automatic t_off_all();
    send(mk(1, 0, 2'd1, 12'h777));
    chk("R4 all powered down", chan_off, 4'b1111);
    chk("R4 outputs zero", dac_out, '0);
    send(mk(0, 0, 2'd1, 12'h0F0));
    chk("R9 only B released", chan_off, 4'b1101);
    chk("R9 B shows held output register", ch(1), 12'h123);
    pulse_load();
    chk("R9 B new code", ch(1), 12'h0F0);
    send(mk(0, 0, 2'd0, 12'h222));
    send(mk(0, 0, 2'd2, 12'h333));
    send(mk(0, 0, 2'd3, 12'h444));
    chk("R9 all released", chan_off, 4'b0000);
  endtask

  task automatic t_overlong();
    ser_sel_n = 1'b0;
    wait_clk(3);
    shift_bits({8'h0, 8'hFF, mk(0, 0, 2'd0, 12'h321)}, 24);
    ser_sel_n = 1'b1;
    wait_clk(8);
    pulse_load();
    chk("R10 last 16 bits used", ch(0), 12'h321);
    chk("R10 no power-down from early bits", chan_off, 4'b0000);
  endtask

  task automatic t_clear();
    ser_sel_n = 1'b0;
    wait_clk(3);
    shift_bits({16'h0, mk(0, 0, 2'd3, 12'h777)}, 16);
    clr_n = 1'b0;
    wait_clk(4);
    chk("R7 outputs zero during clear", dac_out, '0);
    clr_n = 1'b1;
    wait_clk(6);
    pulse_load();
    chk("R7 staging zeroed", dac_out, '0);
    ser_sel_n = 1'b1;
    wait_clk(8);
    pulse_load();
    chk("R7 pending frame kept", ch(3), 12'h777);
    chk("R7 other channel zero", ch(0), 12'h000);
  endtask

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; ser_clk = 1'b0; ser_sel_n = 1'b1;
    ser_din = 1'b0; load_n = 1'b1;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_write_all();
    t_sel_high();
    t_off_one();
    t_off_all();
    t_overlong();
    t_clear();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule